// File: doc/BRIEF.md
# Dual-Edge Input Capture Timer

This block is a free-running down counter with two capture channels, A and B. Each capture pin is synchronised, and an edge detector watches the synchronised level. The edge it looks for is programmed per channel as rising or falling. When that edge appears while capture mode is selected, the counter value is copied into the channel's capture register, and a sticky pending flag for that channel is set. An underflow of the counter in capture mode is latched into the low control bit. Outside capture mode, the same bit acts as the run/stop switch.

A single registered interrupt line merges the flags with their enables. Channel A's enable also gates the underflow flag. An interrupt raised through that enable can therefore come from a capture on A, from an underflow, or from both, and software reads the control register to tell which. Software reaches the control bits, the counter and the two capture registers through a small synchronous register bus. Read data is registered.

Top module: `cap_timer`

## Requirements
- R1: After a synchronous reset, the following are zero: the control register, the counter, both capture registers, the read data and the interrupt output.
- R2: The counter decrements by one on each cycle with `tick_i` high while it is counting, and wraps from 0x0000 to 0xFFFF. A bus write to the counter loads it, and the write takes priority over a decrement in the same cycle.
- R3: With capture mode off (control bit 5 = 0), the counter counts only while control bit 0 (run) is 1, and holds its value while that bit is 0. With capture mode on, it counts on every tick.
- R4: In capture mode, the selected edge on `pin_a_i` copies the counter into capture register A. Control bit 6 selects the edge: 0 = rising, 1 = falling. If a decrement happens in the same cycle, the value captured is the one before the decrement.
- R5: Channel B behaves in the same way into capture register B. Its edge is selected by control bit 7, independently of channel A.
- R6: A capture on A sets control bit 1 and a capture on B sets control bit 2. Each bit stays set until software writes 0 to it. If a capture and a clearing write happen in the same cycle, the flag ends up set.
- R7: In capture mode, an underflow (a decrement from 0x0000) sets control bit 0.
- R8: `irq_o` is registered and is the OR of three terms: bit 1 AND bit 3; bit 0 AND bit 3, counted only in capture mode; and bit 2 AND bit 4. Bit 3 is the A enable and bit 4 is the B enable.
- R9: An edge of the opposite polarity to the selected one changes neither the capture register nor the pending flag.
- R10: With capture mode off, edges on the pins capture nothing and set no flag.
- R11: The bus has four addresses: 0 = control (bits 7:0, upper bits read 0), 1 = counter (read/write), 2 = capture A (read-only), 3 = capture B (read-only). `bus_rdata_o` shows the addressed register one cycle after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data |
| pin_a_i | input | 1 | Capture pin A (asynchronous) |
| pin_b_i | input | 1 | Capture pin B (asynchronous) |
| tick_i | input | 1 | Prescaled count-enable strobe |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted counter or capture register shows up on the read port in the cycle after its address is selected. A capture pulse on the wrong edge, or a capture taken outside capture mode, changes a capture register that the bench expects to hold its value. A flag that clears on its own, or that loses the race against a clearing write, shows up in the control word read back on the next access. Within one further cycle it also shows up as an `irq_o` level that disagrees with the flag-and-enable combination the bench programmed. An underflow that is not latched leaves bit 0 low right after the wrap from 0x0000 to 0xFFFF.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CAPA = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_CAPB = 2'd3;

  localparam int CTRL_W = 8;

  // bit order from msb to lsb matches the control word layout
  typedef struct packed {
    logic edge_b;    // 7: 1 = falling edge on B
    logic edge_a;    // 6: 1 = falling edge on A
    logic cap_mode;  // 5: capture behaviour enabled
    logic en_b;      // 4
    logic en_a;      // 3
    logic pend_b;    // 2
    logic pend_a;    // 1
    logic run_uf;    // 0: run control, or underflow flag in capture mode
  } ctrl_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic pin_i,
  input  logic fall_sel_i,
  output logic hit_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl = sync_q[STAGES-1];

  always_comb begin
    if (fall_sel_i) hit_o = prev_q & ~lvl;
    else            hit_o = ~prev_q & lvl;
  end
endmodule

// File: rtl/cap_down_cnt.sv
module cap_down_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] count_o,
  output logic         uflow_o
);
  logic [W-1:0] count_q;
  logic         step;

  assign step    = run_i & tick_i & ~ld_i;
  assign uflow_o = step & (count_q == '0);
  assign count_o = count_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)     count_q <= '0;
    else if (ld_i) count_q <= ld_val_i;
    else if (step) count_q <= count_q - 1'b1;
  end
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  input  logic              pin_a_i,
  input  logic              pin_b_i,
  input  logic              tick_i,
  output logic              irq_o
);
  localparam int N_CH   = 2;
  localparam int PAD_W  = CNT_W - CTRL_W;

  ctrl_t                       ctrl_q;
  logic                        wr_ctrl;
  logic                        wr_cnt;
  logic [CNT_W-1:0]            cnt_val;
  logic                        uflow;
  logic [N_CH-1:0]             pins;
  logic [N_CH-1:0]             edge_sel;
  logic [N_CH-1:0]             hit;
  logic [N_CH-1:0]             cap_evt;
  logic [N_CH-1:0][CNT_W-1:0]  cap_vals;
  logic [CNT_W-1:0]            rdata_q;
  logic                        irq_q;

  assign wr_ctrl  = bus_we_i & (bus_addr_i == ADR_CTRL);
  assign wr_cnt   = bus_we_i & (bus_addr_i == ADR_CNT);
  assign pins     = {pin_b_i, pin_a_i};
  assign edge_sel = {ctrl_q.edge_b, ctrl_q.edge_a};

  cap_down_cnt #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .run_i    (ctrl_q.cap_mode | ctrl_q.run_uf),
    .tick_i   (tick_i),
    .ld_i     (wr_cnt),
    .ld_val_i (bus_wdata_i),
    .count_o  (cnt_val),
    .uflow_o  (uflow)
  );

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [CNT_W-1:0] val_q;

    cap_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .pin_i      (pins[ch]),
      .fall_sel_i (edge_sel[ch]),
      .hit_o      (hit[ch])
    );

    assign cap_evt[ch] = hit[ch] & ctrl_q.cap_mode;

    always_ff @(posedge clk_i) begin
      if (rst_i)            val_q <= '0;
      else if (cap_evt[ch]) val_q <= cnt_val;
    end

    assign cap_vals[ch] = val_q;
  end

  // control register: hardware events are applied last so they win
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
      if (cap_evt[0]) ctrl_q.pend_a <= 1'b1;
      if (cap_evt[1]) ctrl_q.pend_b <= 1'b1;
      if (uflow && ctrl_q.cap_mode) ctrl_q.run_uf <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= ((ctrl_q.pend_a | (ctrl_q.run_uf & ctrl_q.cap_mode)) & ctrl_q.en_a)
             | (ctrl_q.pend_b & ctrl_q.en_b);
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      rdata_q <= '0;
    end else begin
      unique case (bus_addr_i)
        ADR_CTRL: rdata_q <= {{PAD_W{1'b0}}, ctrl_q};
        ADR_CNT:  rdata_q <= cnt_val;
        ADR_CAPA: rdata_q <= cap_vals[0];
        default:  rdata_q <= cap_vals[1];
      endcase
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             wr_ctrl_i,
  input logic             wr_cnt_i,
  input logic             wpa_i,
  input logic             tick_i,
  input logic [7:0]       ctrl_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [1:0]       evt_i,
  input logic [CNT_W-1:0] capa_i,
  input logic [CNT_W-1:0] capb_i,
  input logic             irq_i
);
  // R4
  cap_a_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_i[0] |=> capa_i == $past(cnt_i));

  // R5
  cap_b_value_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_i[1] |=> capb_i == $past(cnt_i));

  // R6
  pend_a_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i[1] && !(wr_ctrl_i && !wpa_i)) |=> ctrl_i[1]);

  // R6
  evt_a_wins_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    evt_i[0] |=> ctrl_i[1]);

  // R7
  uflow_latch_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ctrl_i[5] && tick_i && cnt_i == '0 && !wr_cnt_i) |=> (ctrl_i[0] && cnt_i == '1));

  // R3
  stopped_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_i[5] && !ctrl_i[0] && !wr_cnt_i) |=> $stable(cnt_i));

  // R8
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!ctrl_i[3] && !ctrl_i[4]) |=> !irq_i);

  // R10
  no_capture_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !ctrl_i[5] |=> ($stable(capa_i) && $stable(capb_i)));
endmodule

bind cap_timer cap_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .wr_ctrl_i (wr_ctrl),
  .wr_cnt_i  (wr_cnt),
  .wpa_i     (bus_wdata_i[1]),
  .tick_i    (tick_i),
  .ctrl_i    (ctrl_q),
  .cnt_i     (cnt_val),
  .evt_i     (cap_evt),
  .capa_i    (cap_vals[0]),
  .capb_i    (cap_vals[1]),
  .irq_i     (irq_o)
);

// File: tb/sim_cap_timer.sv
`timescale 1ns/1ps
module sim_cap_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        tick = 1'b0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    bit          is_irq;
    string       tag;
    logic [15:0] exp;
    int          due;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cap_timer u0 (
    .clk_i(clk), .rst_i(rst), .bus_addr_i(addr), .bus_we_i(we),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_a_i(pin_a),
    .pin_b_i(pin_b), .tick_i(tick), .irq_o(irq)
  );

  // monitor: compare items when their cycle arrives
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      logic [15:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {15'd0, irq} : rdata;
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic exp_rd(input logic [1:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(negedge clk);
    addr = a;
    it.is_irq = 1'b0; it.tag = tag; it.exp = e; it.due = cyc + 1;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic exp_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.tag = tag; it.exp = {15'd0, e}; it.due = cyc + 1;
    sb.push_back(it);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_pin(input bit is_b, input logic v);
    @(negedge clk);
    if (is_b) pin_b = v; else pin_a = v;
    wait_n(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    // R1 reset state
    exp_rd(2'd0, 16'h0000, "R1 ctrl");
    exp_rd(2'd1, 16'h0000, "R1 cnt");
    exp_rd(2'd2, 16'h0000, "R1 capA");
    exp_rd(2'd3, 16'h0000, "R1 capB");
    exp_irq(1'b0, "R1 irq");

    // R11 counter load and readback
    wr(2'd1, 16'h1234);
    exp_rd(2'd1, 16'h1234, "R11 cnt load");

    // R4 rising capture on A, R6 flag, R8 masked
    wr(2'd0, 16'h0020);
    set_pin(1'b0, 1'b1);
    exp_rd(2'd2, 16'h1234, "R4 capA rise");
    exp_rd(2'd0, 16'h0022, "R6 pend A set");
    exp_irq(1'b0, "R8 irq masked");

    // R8 enable A, R6 clear by write of 0
    wr(2'd0, 16'h002A);
    wait_n(2);
    exp_irq(1'b1, "R8 irq pend A");
    wr(2'd0, 16'h0028);
    exp_rd(2'd0, 16'h0028, "R6 pend A cleared");
    wait_n(1);
    exp_irq(1'b0, "R8 irq after clear");

    // R9 falling edge ignored while rising selected
    wr(2'd1, 16'h0500);
    set_pin(1'b0, 1'b0);
    exp_rd(2'd2, 16'h1234, "R9 capA unchanged");
    exp_rd(2'd0, 16'h0028, "R9 no flag");

    // R4 falling select on A
    wr(2'd0, 16'h0068);
    set_pin(1'b0, 1'b1);
    exp_rd(2'd2, 16'h1234, "R9 rise ignored on fall select");
    exp_rd(2'd0, 16'h0068, "R9 no flag on rise");
    set_pin(1'b0, 1'b0);
    exp_rd(2'd2, 16'h0500, "R4 capA fall");
    exp_rd(2'd0, 16'h006A, "R6 pend A fall");
    exp_irq(1'b1, "R8 irq A fall");

    // R5 channel B rising, independent select
    wr(2'd0, 16'h0078);
    wait_n(1);
    exp_irq(1'b0, "R8 irq cleared");
    set_pin(1'b1, 1'b1);
    exp_rd(2'd3, 16'h0500, "R5 capB rise");
    exp_rd(2'd0, 16'h007C, "R6 pend B set");
    exp_irq(1'b1, "R8 irq pend B");
    wr(2'd0, 16'h0060);
    wait_n(1);
    exp_irq(1'b0, "R8 irq disabled");

    // R6 event beats clearing write in the same cycle
    set_pin(1'b1, 1'b0);
    @(negedge clk); pin_b = 1'b1;
    @(negedge clk);
    @(negedge clk); addr = 2'd0; wdata = 16'h0060; we = 1'b1;
    @(negedge clk); we = 1'b0;
    exp_rd(2'd0, 16'h0064, "R6 event wins over clear");
    wr(2'd0, 16'h0060);

    // R2 and R7 underflow wrap in capture mode
    wr(2'd1, 16'h0002);
    wr(2'd0, 16'h0068);
    ticks(3);
    exp_rd(2'd1, 16'hFFFF, "R2 wrap");
    exp_rd(2'd0, 16'h0069, "R7 underflow flag");
    exp_irq(1'b1, "R8 irq underflow");
    ticks(1);
    exp_rd(2'd1, 16'hFFFE, "R2 decrement");

    // R2 write beats a tick in the same cycle
    @(negedge clk); addr = 2'd1; wdata = 16'h00AA; we = 1'b1; tick = 1'b1;
    @(negedge clk); we = 1'b0; tick = 1'b0;
    exp_rd(2'd1, 16'h00AA, "R2 load beats tick");

    // R3 stopped outside capture mode
    wr(2'd0, 16'h0008);
    ticks(3);
    exp_rd(2'd1, 16'h00AA, "R3 stopped");
    wr(2'd0, 16'h0009);
    wait_n(1);
    exp_irq(1'b0, "R8 run bit not an irq source");
    ticks(2);
    exp_rd(2'd1, 16'h00A8, "R3 running");

    // R10 no capture outside capture mode
    set_pin(1'b0, 1'b1);
    exp_rd(2'd2, 16'h0500, "R10 capA unchanged");
    exp_rd(2'd0, 16'h0009, "R10 no flag");

    wait_n(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule